// File: doc/BRIEF.md
# Power Controller Event Register Bank

This block is the byte-wide register file that sits behind the serial management port of a four-port power controller. It takes transactions that a separate serial front end has already decoded into four items: a start or repeated-start indication, a pointer-load byte, a data-byte write strobe and a data-byte read strobe. One address pointer selects the register for every data byte. The pointer advances after each data byte, which lets a host walk through several registers after sending a single address.

Single-cycle hardware event pulses from the port logic are captured in five sticky event registers: power, detect, fault, startup and supply. Each register can be read at two addresses. At the even address a read leaves the bits in place. At the odd address a read returns the bits and then clears them. Every event register feeds one or two bits of a read-only summary register. The summary is combined with a writable enable mask to drive an active-high interrupt line. Address map: 0x00 summary, 0x01 mask, 0x02/0x03 power, 0x04/0x05 detect, 0x06/0x07 fault, 0x08/0x09 startup, 0x0A/0x0B supply. Every other address reads as zero.

Top module: `pse_evt_regbank`

## Requirements
- R1: After each data-byte read or write, the pointer advances by one while it is below 0x71. A sweep of reads from 0x00 therefore returns the registers in address order.
- R2: At 0x71 the pointer no longer moves on data bytes, and a pointer-load value above 0x71 is taken as 0x71. The pointer never wraps to 0x00.
- R3: A start or repeated-start indication leaves the pointer unchanged, so a read that follows a pointer load returns the addressed register.
- R4: Only 0x01 (mask) is writable. Writes to the summary, event or unmapped addresses change no register.
- R5: A read at an event register's even address returns its bits and leaves them set.
- R6: A read at an event register's odd address returns its bits, and the register reads zero afterwards.
- R7: An event pulse in the same cycle as a clearing read of its register leaves that bit set after the read.
- R8: Bit layout, with port n on bit n of each nibble. Power: power-good change in [7:4], power-enable change in [3:0]. Detect: classification in [7:4], detection in [3:0]. Fault: disconnect in [7:4], current-limit timeout in [3:0]. Startup: startup overcurrent in [7:4], startup timeout in [3:0]. Supply: evt_supply[3:0] appears in [7:4] (thermal, bad pass device, rail A undervoltage, rail B undervoltage), and [3:0] reads zero.
- R9: Summary bit 7..0 = OR of supply, OR of startup, OR of fault[3:0], OR of detect[7:4], OR of detect[3:0], OR of fault[7:4], OR of power[7:4], OR of power[3:0].
- R10: irq is high exactly when some summary bit and the mask bit at the same position are both 1.
- R11: After reset all event registers are zero, the pointer is 0x00 and the mask reads 0x80.
- R12: An event pulse sets its bit, and the bit stays set until a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| ptr_wr | input | 1 | Load the pointer from wdata |
| wr_en | input | 1 | Data-byte write strobe |
| rd_en | input | 1 | Data-byte read strobe |
| wdata | input | 8 | Pointer or write data |
| rdata | output | 8 | Register at the current pointer |
| evt_pgood | input | 4 | Power-good change pulses, one per port |
| evt_pwren | input | 4 | Power-enable change pulses |
| evt_class | input | 4 | Classification event pulses |
| evt_detect | input | 4 | Detection event pulses |
| evt_discon | input | 4 | Disconnect event pulses |
| evt_ilim | input | 4 | Current-limit timeout pulses |
| evt_stoc | input | 4 | Startup overcurrent pulses |
| evt_sttmo | input | 4 | Startup timeout pulses |
| evt_supply | input | 4 | Thermal, bad pass device, rail A and rail B undervoltage pulses |
| irq | output | 1 | Masked interrupt, active high |

## Verification
The pointer assertions assume that the front end presents at most one of pointer load, write and read in any cycle. That assumption is itself checked as an assertion, and the bench issues each bus operation as its own single-cycle strobe with idle cycles in between. The event pulses may coincide with any bus operation. The bench drives one such overlap on purpose, a clearing read together with a new event, and otherwise places event pulses in idle cycles.

// File: rtl/pse_evt_pkg.sv
package pse_evt_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int NREG     = 5;
  localparam int NPORT    = 4;
  localparam logic [AW-1:0] A_SUM  = 8'h00;
  localparam logic [AW-1:0] A_MASK = 8'h01;
  localparam int EVT_BASE = 2;
  typedef enum int {EV_PWR = 0, EV_DET = 1, EV_FLT = 2, EV_STU = 3, EV_SUP = 4} evt_idx_e;
endpackage

// File: rtl/pse_evt_ptr.sv
module pse_evt_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] TOP = 8'h71
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_set,
  input  logic          adv,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr;
    if (ptr_set) begin
      ptr_en = 1'b1;
      ptr_d  = (load_val > TOP) ? TOP : load_val;
    end else if (adv && (ptr < TOP)) begin
      ptr_en = 1'b1;
      ptr_d  = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end

  assert_ptr_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ptr_set && ptr < TOP) |=> ptr == $past(ptr) + 1'b1);
  assert_ptr_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ptr_set && ptr == TOP) |=> ptr == TOP);
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ptr_set) |=> $stable(ptr));
  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOP);
endmodule

// File: rtl/pse_evt_sticky.sv
module pse_evt_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_d  = (q & ~{W{clr_i}}) | set_i;
    q_en = clr_i || (set_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  assert_evt_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q & $past(set_i)) == $past(set_i));
  assert_evt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (q & $past(q)) == $past(q));
endmodule

// File: rtl/pse_evt_irq.sv
module pse_evt_irq
  import pse_evt_pkg::*;
#(
  parameter logic [DW-1:0] MASK_RST = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [DW-1:0]      wdata,
  input  logic [NREG*DW-1:0] evt_flat,
  output logic [DW-1:0]      summary,
  output logic [DW-1:0]      mask,
  output logic               irq
);
  localparam int H = DW / 2;
  logic [DW-1:0] r_pwr, r_det, r_flt, r_stu, r_sup;

  always_comb begin
    r_pwr = evt_flat[EV_PWR*DW +: DW];
    r_det = evt_flat[EV_DET*DW +: DW];
    r_flt = evt_flat[EV_FLT*DW +: DW];
    r_stu = evt_flat[EV_STU*DW +: DW];
    r_sup = evt_flat[EV_SUP*DW +: DW];
    summary[7] = |r_sup;
    summary[6] = |r_stu;
    summary[5] = |r_flt[H-1:0];
    summary[4] = |r_det[DW-1:H];
    summary[3] = |r_det[H-1:0];
    summary[2] = |r_flt[DW-1:H];
    summary[1] = |r_pwr[DW-1:H];
    summary[0] = |r_pwr[H-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= MASK_RST;
    else if (mask_we) mask <= wdata;
  end

  assign irq = |(summary & mask);

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask));
  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask == $past(wdata));
endmodule

// File: rtl/pse_evt_regbank.sv
module pse_evt_regbank
  import pse_evt_pkg::*;
#(
  parameter logic [AW-1:0] TOP_ADDR = 8'h71,
  parameter logic [DW-1:0] MASK_RST = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          ptr_wr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [3:0]    evt_pgood,
  input  logic [3:0]    evt_pwren,
  input  logic [3:0]    evt_class,
  input  logic [3:0]    evt_detect,
  input  logic [3:0]    evt_discon,
  input  logic [3:0]    evt_ilim,
  input  logic [3:0]    evt_stoc,
  input  logic [3:0]    evt_sttmo,
  input  logic [3:0]    evt_supply,
  output logic          irq
);
  logic [1:0]    rst_sync;
  logic          rst_q;
  logic [AW-1:0] ptr;
  logic [DW-1:0] set_v [NREG];
  logic [DW-1:0] evt_q [NREG];
  logic [NREG-1:0] clr_v;
  logic [NREG*DW-1:0] evt_flat;
  logic [DW-1:0] summary, mask;
  logic          bus_start_unused;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // a start or repeated start has no effect on the pointer
  assign bus_start_unused = bus_start;

  pse_evt_ptr #(.AW(AW), .TOP(TOP_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_q), .ptr_set(ptr_wr), .adv(wr_en || rd_en),
    .load_val(wdata), .ptr(ptr)
  );

  always_comb begin
    set_v[EV_PWR] = {evt_pgood, evt_pwren};
    set_v[EV_DET] = {evt_class, evt_detect};
    set_v[EV_FLT] = {evt_discon, evt_ilim};
    set_v[EV_STU] = {evt_stoc, evt_sttmo};
    set_v[EV_SUP] = {evt_supply, 4'b0000};
  end

  for (genvar i = 0; i < NREG; i++) begin : g_evt
    localparam logic [AW-1:0] A_PLAIN = AW'(EVT_BASE + 2*i);
    localparam logic [AW-1:0] A_COR   = AW'(EVT_BASE + 2*i + 1);
    assign clr_v[i] = rd_en && (ptr == A_COR);
    pse_evt_sticky #(.W(DW)) u_reg (
      .clk(clk), .rst_n(rst_q), .set_i(set_v[i]), .clr_i(clr_v[i]), .q(evt_q[i])
    );
    assign evt_flat[i*DW +: DW] = evt_q[i];

    assert_cor_clear_R6: assert property (@(posedge clk) disable iff (!rst_q)
      (rd_en && ptr == A_COR) |=> evt_q[i] == $past(set_v[i]));
    assert_plain_keep_R5: assert property (@(posedge clk) disable iff (!rst_q)
      (rd_en && ptr == A_PLAIN) |=> (evt_q[i] & $past(evt_q[i])) == $past(evt_q[i]));
  end

  pse_evt_irq #(.MASK_RST(MASK_RST)) u_irq (
    .clk(clk), .rst_n(rst_q), .mask_we(wr_en && (ptr == A_MASK)), .wdata(wdata),
    .evt_flat(evt_flat), .summary(summary), .mask(mask), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    if (ptr == A_SUM)       rdata = summary;
    else if (ptr == A_MASK) rdata = mask;
    else begin
      for (int i = 0; i < NREG; i++) begin
        if ((ptr >> 1) == AW'((EVT_BASE >> 1) + i)) rdata = evt_q[i];
      end
    end
  end

  assert_single_op_R1: assert property (@(posedge clk) disable iff (!rst_q)
    $countones({ptr_wr, wr_en, rd_en}) <= 1);
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> (evt_flat != '0));
  assert_start_ptr_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_start && !ptr_wr && !wr_en && !rd_en) |=> $stable(ptr));
endmodule

// File: tb/pse_evt_regbank_test.sv
`timescale 1ns/1ps
module pse_evt_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 0, ptr_wr = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [3:0] e_pg = 0, e_pe = 0, e_cls = 0, e_det = 0, e_dis = 0, e_ilim = 0,
              e_soc = 0, e_stm = 0, e_sup = 0;
  logic irq;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  pse_evt_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .ptr_wr(ptr_wr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .evt_pgood(e_pg), .evt_pwren(e_pe), .evt_class(e_cls), .evt_detect(e_det),
    .evt_discon(e_dis), .evt_ilim(e_ilim), .evt_stoc(e_soc), .evt_sttmo(e_stm),
    .evt_supply(e_sup), .irq(irq)
  );

  // behavioural reference
  int m_ev[5] = '{0, 0, 0, 0, 0};
  int m_mask = 'h80;
  int m_ptr = 0;

  function automatic int m_sum();
    int s = 0;
    if (m_ev[4] != 0)            s |= 'h80;
    if (m_ev[3] != 0)            s |= 'h40;
    if ((m_ev[2] & 'h0F) != 0)   s |= 'h20;
    if ((m_ev[1] & 'hF0) != 0)   s |= 'h10;
    if ((m_ev[1] & 'h0F) != 0)   s |= 'h08;
    if ((m_ev[2] & 'hF0) != 0)   s |= 'h04;
    if ((m_ev[0] & 'hF0) != 0)   s |= 'h02;
    if ((m_ev[0] & 'h0F) != 0)   s |= 'h01;
    return s;
  endfunction

  function automatic int m_read();
    if (m_ptr == 0) return m_sum();
    if (m_ptr == 1) return m_mask;
    if (m_ptr >= 2 && m_ptr <= 11) return m_ev[(m_ptr - 2) / 2];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_ev[i] = 0;
      m_mask = 'h80;
      m_ptr = 0;
    end else begin
      int clr;
      int ins[5];
      clr = -1;
      if (rd_en && m_ptr >= 3 && m_ptr <= 11 && (m_ptr % 2) == 1) clr = (m_ptr - 3) / 2;
      ins[0] = {e_pg, e_pe};
      ins[1] = {e_cls, e_det};
      ins[2] = {e_dis, e_ilim};
      ins[3] = {e_soc, e_stm};
      ins[4] = {e_sup, 4'b0000};
      for (int i = 0; i < 5; i++) m_ev[i] = ((i == clr) ? 0 : m_ev[i]) | ins[i];
      if (wr_en && m_ptr == 1) m_mask = wdata;
      if (ptr_wr) m_ptr = (wdata > 8'h71) ? 'h71 : int'(wdata);
      else if ((wr_en || rd_en) && m_ptr < 'h71) m_ptr++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== 8'(m_read())) begin
        fails++;
        $display("FAIL MODEL rdata at ptr %0h: actual %0h expected %0h", m_ptr, rdata, m_read());
      end
      checks++;
      if (irq !== ((m_sum() & m_mask) != 0)) begin
        fails++;
        $display("FAIL MODEL R10 irq: actual %0b expected %0b", irq, (m_sum() & m_mask) != 0);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_ptr(input logic [7:0] a);
    @(negedge clk); ptr_wr = 1; wdata = a;
    @(posedge clk); #1 ptr_wr = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_en = 1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_evts();
    e_pg = 0; e_pe = 0; e_cls = 0; e_det = 0; e_dis = 0; e_ilim = 0;
    e_soc = 0; e_stm = 0; e_sup = 0;
  endtask

  task automatic pulse_end();
    @(posedge clk); #1 clear_evts();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(5);
    // R11 reset state
    rd(v); chk("R11 summary after reset", v, 'h00);
    rd(v); chk("R11 mask after reset", v, 'h80);
    rd(v); chk("R11 power reg after reset", v, 'h00);
    chk("R11 irq after reset", irq, 0);
    // R4 mask is writable
    set_ptr(1); wr(8'hFF); set_ptr(1); rd(v); chk("R4 mask write", v, 'hFF);
    // R12/R8 power register layout
    @(negedge clk); e_pg = 4'b0100; e_pe = 4'b0001; pulse_end();
    idle(2);
    set_ptr(0); rd(v); chk("R9 summary power bits", v, 'h03);
    #1 chk("R10 irq with enabled bits", irq, 1);
    rd(v); chk("R1 next is mask", v, 'hFF);
    rd(v); chk("R8 power layout", v, 'h41);
    rd(v); chk("R6 clearing read returns bits", v, 'h41);
    set_ptr(2); rd(v); chk("R6 cleared after read", v, 'h00);
    #1 chk("R10 irq drops", irq, 0);
    // load all other registers
    @(negedge clk);
    e_sup = 4'b1010; e_cls = 4'b1000; e_det = 4'b0010;
    e_dis = 4'b0001; e_ilim = 4'b1000; e_soc = 4'b0010; e_stm = 4'b0100;
    pulse_end();
    idle(3);
    set_ptr(4); rd(v); chk("R8 detect layout", v, 'h82);
    set_ptr(4); rd(v); chk("R5 plain read keeps bits", v, 'h82);
    set_ptr(6); rd(v); chk("R8 fault layout", v, 'h18);
    set_ptr(8); rd(v); chk("R8 startup layout", v, 'h24);
    set_ptr(10); rd(v); chk("R8 supply layout", v, 'hA0);
    set_ptr(0); rd(v); chk("R9 summary order", v, 'hFC);
    // R10 masking
    set_ptr(1); wr(8'h00); idle(1); chk("R10 irq masked off", irq, 0);
    set_ptr(1); wr(8'h04); idle(1); chk("R10 irq single enable", irq, 1);
    // R4 ignored writes
    set_ptr(4); wr(8'h00); wr(8'h00);
    set_ptr(4); rd(v); chk("R4 event reg not writable", v, 'h82);
    set_ptr(0); wr(8'h00); set_ptr(0); rd(v); chk("R4 summary not writable", v, 'hFC);
    set_ptr(8'h0C); wr(8'h55); set_ptr(1); rd(v); chk("R4 mask untouched by other writes", v, 'h04);
    // R3 repeated start keeps pointer
    set_ptr(8'h0A);
    @(negedge clk); bus_start = 1; @(posedge clk); #1 bus_start = 0;
    rd(v); chk("R3 read after repeated start", v, 'hA0);
    // R7 event during clearing read
    set_ptr(5);
    @(negedge clk); rd_en = 1; e_det = 4'b0100; #1 v = rdata;
    @(posedge clk); #1 rd_en = 0; clear_evts();
    chk("R7 clearing read data", v, 'h82);
    set_ptr(4); rd(v); chk("R7 new event survives clear", v, 'h04);
    // R1 sweep
    set_ptr(0);
    begin
      int exp_s[13] = '{'hEC, 'h04, 0, 0, 'h04, 'h04, 'h18, 'h18, 'h24, 'h24, 'hA0, 'hA0, 0};
      for (int k = 0; k < 13; k++) begin
        rd(v); chk($sformatf("R1 sweep addr %0h", k), v, exp_s[k]);
      end
    end
    set_ptr(0); rd(v); chk("R6 all cleared by sweep", v, 'h00);
    // R2 saturation
    @(negedge clk); e_pe = 4'b0001; pulse_end();
    set_ptr(8'h70); rd(v); rd(v); rd(v);
    chk("R2 no wrap after top", v, 'h00);
    wr(8'h33); wr(8'h33); rd(v); chk("R2 writes at top", v, 'h00);
    set_ptr(1); rd(v); chk("R2 mask safe from top writes", v, 'h04);
    set_ptr(8'hFF); rd(v); rd(v); chk("R2 load clamps to top", v, 'h00);
    set_ptr(0); rd(v); chk("R12 power event still held", v, 'h01);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule